// File: doc/BRIEF.md
# Reset and Sleep Wake Sequencer

This block sequences reset and low-power operation for a small 8-bit microcontroller core. It takes a power-on detect, an active-low external reset pin, a watchdog timeout strobe, a sleep instruction strobe, a sleep-mode select bit and a bank of active-low wake-up pins. Each wake-up pin has its own wake enable and input-mode qualifier. From these inputs it drives the core reset hold, the oscillator enable, the strobes that load register reset values, the watchdog clear and run controls, and two status flags, T and P, that record what caused the last reset or wake.

After any reset, the core is held for a parameterised number of clock cycles, one oscillator start-up period. The block offers two sleep modes. Light-off sleep (selected when the mode bit is 1) can only end in a full reset. Pin-wake sleep (selected when the mode bit is 0) resumes execution in-line when a qualified wake pin goes low. In that mode, a watchdog timeout or the external reset still forces a full reset.

The state machine has four states. `ST_HOLD` holds reset and counts the start-up period. `ST_RUN` is normal execution. `ST_SLEEP1` is light-off sleep and `ST_SLEEP2` is pin-wake sleep. The transitions are:
- HOLD→RUN when the start-up period completes with the reset pin released.
- RUN→HOLD on the reset pin or a watchdog hit.
- RUN→SLEEP1 or RUN→SLEEP2 on the sleep strobe, chosen by the mode bit.
- SLEEP1→HOLD and SLEEP2→HOLD on the reset pin or a watchdog hit.
- SLEEP2→RUN on a qualified wake pin.

Top module: `rst_sleep_ctrl`

## Requirements
- R1: After power-on detect is released, `core_rst` stays high for exactly OST_CYCLES cycles, and `osc_en` is high whenever `core_rst` is high.
- R2: While `core_rst` is high, `reg_load` is high. The constant outputs are: program counter reset value all ones, timer-control reset value 8'hBF (all ones except bit 6), I/O-control AND mask 8'hB7 (clears bits 3 and 6), and I/O-control OR mask 8'h31 (sets bits 0, 4 and 5).
- R3: `por_load` is high only during a hold that began with power-on detect, never during a hold caused by the watchdog or the reset pin.
- R4: `wdt_clr` is high throughout the hold. `wdt_run` is low during the hold and otherwise equals `cfg_wdt_en`. A watchdog timeout has no effect when `cfg_wdt_en` is 0.
- R5: The flags are encoded {T,P} as follows: power-on gives 11, a watchdog hit while running gives 01, a watchdog hit during either sleep gives 00, and a pin wake gives 10.
- R6: A sleep strobe with mode bit 1 enters light-off sleep. In this state `osc_en` is 0, `wdt_clr` pulses for exactly the first sleep cycle, and `wdt_run` follows `cfg_wdt_en`. Wake pins have no effect.
- R7: A watchdog hit in light-off sleep causes a full reset with {T,P}=00.
- R8: In pin-wake sleep (mode bit 0), the core returns to run without any reset when some pin i has wake_n[i]=0, wake_en[i]=1 and pin_in_mode[i]=1. It sets {T,P}=10 and restores `osc_en`. A pin that fails any of these conditions does not wake the core.
- R9: In either sleep mode, the reset pin low causes a full reset with {T,P}=10. In pin-wake sleep, a watchdog hit causes a full reset with {T,P}=00.
- R10: The reset pin low while running starts a hold and leaves the flags unchanged. The hold lasts while the pin stays low, then for OST_CYCLES more cycles.
- R11: The reset pin and the wake pins pass through a two-flop synchroniser. A change on either is acted on at the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_det | input | 1 | Power-on detect, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_timeout | input | 1 | Watchdog timeout strobe |
| sleep_cmd | input | 1 | Sleep instruction strobe |
| slp_mode_sel | input | 1 | 1 selects light-off sleep, 0 selects pin-wake sleep |
| cfg_wdt_en | input | 1 | Watchdog enable configuration option |
| wake_n | input | NWAKE | Wake-up pins, active low |
| wake_en | input | NWAKE | Per-pin wake enable |
| pin_in_mode | input | NWAKE | Per-pin input-mode setting |
| core_rst | output | 1 | Core reset hold |
| osc_en | output | 1 | Oscillator enable |
| reg_load | output | 1 | Load register reset values |
| por_load | output | 1 | Clear status bits 5..6 and select bits 6..7 (power-on only) |
| wdt_clr | output | 1 | Clear watchdog and prescaler |
| wdt_run | output | 1 | Watchdog enable |
| flag_t | output | 1 | Time-out status flag |
| flag_p | output | 1 | Power-down status flag |
| pc_rst_val | output | PC_W | Program counter reset value |
| tcr_rst_val | output | 8 | Timer-control reset value |
| iocr_and_mask | output | 8 | I/O-control reset AND mask |
| iocr_or_mask | output | 8 | I/O-control reset OR mask |

## Verification
The wake qualifier is swept over every combination of pin level, wake enable and input mode on three pins. This separates the single qualifying case from every case with one condition missing. The reset sources are driven in each state: the watchdog and the reset pin while running, in light-off sleep and in pin-wake sleep. This distinguishes the four flag encodings and shows that running-state pin resets preserve the flags. Hold lengths are measured after power-on, after a watchdog hit and after the reset pin is released. These measurements separate the bare start-up count from the count that adds synchroniser latency. A watchdog strobe with the option off, and wake pins toggled during light-off sleep, show both stimuli to be ignored.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_RUN    = 2'd1,
        ST_SLEEP1 = 2'd2,
        ST_SLEEP2 = 2'd3
    } rsc_state_e;

    localparam int          CTRL_W      = 8;
    localparam int          TCR_INT_BIT = 6;
    localparam logic [7:0]  IOCR_CLR    = 8'b0100_1000;
    localparam logic [7:0]  IOCR_SET    = 8'b0011_0001;

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         arst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or posedge arst) begin
            if (arst) begin
                stage1[i] <= RST_VAL[i];
                q[i]      <= RST_VAL[i];
            end else begin
                stage1[i] <= d[i];
                q[i]      <= stage1[i];
            end
        end
    end

endmodule

// File: rtl/rsc_ost_timer.sv
module rsc_ost_timer #(
    parameter int OST_CYCLES = 18000
) (
    input  logic clk,
    input  logic arst,
    input  logic clr,
    output logic done
);

    localparam int CW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LAST);

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (arst)
        cnt <= LAST);

endmodule

// File: rtl/rsc_wake_qual.sv
module rsc_wake_qual #(
    parameter int NWAKE = 8
) (
    input  logic [NWAKE-1:0] wake_n_s,
    input  logic [NWAKE-1:0] wake_en,
    input  logic [NWAKE-1:0] pin_in_mode,
    output logic             wake_any
);

    logic [NWAKE-1:0] hit;

    for (genvar i = 0; i < NWAKE; i++) begin : g_pin
        assign hit[i] = ~wake_n_s[i] & wake_en[i] & pin_in_mode[i];
    end

    assign wake_any = |hit;

endmodule

// File: rtl/rst_sleep_ctrl.sv
module rst_sleep_ctrl
    import rsc_pkg::*;
#(
    parameter int NWAKE      = 8,
    parameter int OST_CYCLES = 18000,
    parameter int PC_W       = 11
) (
    input  logic              clk,
    input  logic              por_det,
    input  logic              ext_rst_n,
    input  logic              wdt_timeout,
    input  logic              sleep_cmd,
    input  logic              slp_mode_sel,
    input  logic              cfg_wdt_en,
    input  logic [NWAKE-1:0]  wake_n,
    input  logic [NWAKE-1:0]  wake_en,
    input  logic [NWAKE-1:0]  pin_in_mode,
    output logic              core_rst,
    output logic              osc_en,
    output logic              reg_load,
    output logic              por_load,
    output logic              wdt_clr,
    output logic              wdt_run,
    output logic              flag_t,
    output logic              flag_p,
    output logic [PC_W-1:0]   pc_rst_val,
    output logic [CTRL_W-1:0] tcr_rst_val,
    output logic [CTRL_W-1:0] iocr_and_mask,
    output logic [CTRL_W-1:0] iocr_or_mask
);

    localparam int SW = NWAKE + 1;

    rsc_state_e state, state_n;
    logic       t_n, p_n;
    logic       por_hold;
    logic       slp_pulse, enter_slp;
    logic       ext_s;
    logic [NWAKE-1:0] wake_s;
    logic       wake_any;
    logic       ost_done;
    logic       wdt_hit;

    rsc_sync #(.W(SW), .RST_VAL('1)) u_sync (
        .clk  (clk),
        .arst (por_det),
        .d    ({ext_rst_n, wake_n}),
        .q    ({ext_s, wake_s})
    );

    rsc_wake_qual #(.NWAKE(NWAKE)) u_wq (
        .wake_n_s    (wake_s),
        .wake_en     (wake_en),
        .pin_in_mode (pin_in_mode),
        .wake_any    (wake_any)
    );

    rsc_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
        .clk  (clk),
        .arst (por_det),
        .clr  ((state != ST_HOLD) || !ext_s),
        .done (ost_done)
    );

    assign wdt_hit = wdt_timeout && cfg_wdt_en;

    always_comb begin
        state_n   = state;
        t_n       = flag_t;
        p_n       = flag_p;
        enter_slp = 1'b0;
        unique case (state)
            ST_HOLD: begin
                if (ost_done && ext_s) state_n = ST_RUN;
            end
            ST_RUN: begin
                if (!ext_s) begin
                    state_n = ST_HOLD;
                end else if (wdt_hit) begin
                    state_n = ST_HOLD;
                    t_n = 1'b0;
                    p_n = 1'b1;
                end else if (sleep_cmd) begin
                    enter_slp = 1'b1;
                    state_n   = slp_mode_sel ? ST_SLEEP1 : ST_SLEEP2;
                end
            end
            ST_SLEEP1, ST_SLEEP2: begin
                if (!ext_s) begin
                    state_n = ST_HOLD;
                    t_n = 1'b1;
                    p_n = 1'b0;
                end else if (wdt_hit) begin
                    state_n = ST_HOLD;
                    t_n = 1'b0;
                    p_n = 1'b0;
                end else if (state == ST_SLEEP2 && wake_any) begin
                    state_n = ST_RUN;
                    t_n = 1'b1;
                    p_n = 1'b0;
                end
            end
            default: state_n = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or posedge por_det) begin
        if (por_det) begin
            state     <= ST_HOLD;
            flag_t    <= 1'b1;
            flag_p    <= 1'b1;
            por_hold  <= 1'b1;
            slp_pulse <= 1'b0;
        end else begin
            state     <= state_n;
            flag_t    <= t_n;
            flag_p    <= p_n;
            slp_pulse <= enter_slp;
            if (state == ST_HOLD && state_n == ST_RUN) por_hold <= 1'b0;
        end
    end

    always_comb begin
        core_rst = (state == ST_HOLD);
        osc_en   = !(state == ST_SLEEP1 || state == ST_SLEEP2);
        reg_load = core_rst;
        por_load = core_rst && por_hold;
        wdt_clr  = core_rst || slp_pulse;
        wdt_run  = cfg_wdt_en && !core_rst;
    end

    assign pc_rst_val    = '1;
    assign tcr_rst_val   = ~(CTRL_W'(1) << TCR_INT_BIT);
    assign iocr_and_mask = ~IOCR_CLR;
    assign iocr_or_mask  = IOCR_SET;

    // R1
    rst_osc_chk: assert property (@(posedge clk) disable iff (por_det)
        core_rst |-> osc_en);

    // R4
    wdt_hold_chk: assert property (@(posedge clk) disable iff (por_det)
        core_rst |-> (wdt_clr && !wdt_run));

    // R3
    por_in_hold_chk: assert property (@(posedge clk) disable iff (por_det)
        por_load |-> core_rst);

    // R7
    s1_wdt_chk: assert property (@(posedge clk) disable iff (por_det)
        (state == ST_SLEEP1 && ext_s && wdt_hit) |=> (core_rst && !flag_t && !flag_p));

    // R8
    s2_wake_chk: assert property (@(posedge clk) disable iff (por_det)
        (state == ST_SLEEP2 && ext_s && !wdt_hit && wake_any)
            |=> (!core_rst && osc_en && flag_t && !flag_p));

    // R10
    pin_run_chk: assert property (@(posedge clk) disable iff (por_det)
        (state == ST_RUN && !ext_s) |=> (core_rst && $stable(flag_t) && $stable(flag_p)));

endmodule

// File: tb/sim_rst_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_rst_sleep_ctrl;

    localparam int NW  = 3;
    localparam int OST = 16;
    localparam int PCW = 11;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic por_det = 1'b1, ext_rst_n = 1'b1, wdt_timeout = 1'b0;
    logic sleep_cmd = 1'b0, slp_mode_sel = 1'b1, cfg_wdt_en = 1'b1;
    logic [NW-1:0] wake_n = '1, wake_en = '0, pin_in_mode = '0;
    logic core_rst, osc_en, reg_load, por_load, wdt_clr, wdt_run, flag_t, flag_p;
    logic [PCW-1:0] pc_rst_val;
    logic [7:0] tcr_rst_val, iocr_and_mask, iocr_or_mask;

    int vecs = 0, errs = 0;

    rst_sleep_ctrl #(.NWAKE(NW), .OST_CYCLES(OST), .PC_W(PCW)) u0 (
        .clk(clk), .por_det(por_det), .ext_rst_n(ext_rst_n), .wdt_timeout(wdt_timeout),
        .sleep_cmd(sleep_cmd), .slp_mode_sel(slp_mode_sel), .cfg_wdt_en(cfg_wdt_en),
        .wake_n(wake_n), .wake_en(wake_en), .pin_in_mode(pin_in_mode),
        .core_rst(core_rst), .osc_en(osc_en), .reg_load(reg_load), .por_load(por_load),
        .wdt_clr(wdt_clr), .wdt_run(wdt_run), .flag_t(flag_t), .flag_p(flag_p),
        .pc_rst_val(pc_rst_val), .tcr_rst_val(tcr_rst_val),
        .iocr_and_mask(iocr_and_mask), .iocr_or_mask(iocr_or_mask)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic hold_len(output int n);
        n = 0;
        while (core_rst && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_wdt();
        wdt_timeout = 1'b1; @(negedge clk); wdt_timeout = 1'b0;
    endtask

    task automatic do_sleep(input logic mode);
        slp_mode_sel = mode; sleep_cmd = 1'b1; @(negedge clk); sleep_cmd = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        int n;
        logic exp;
        cyc(2);
        // R1 R2 R3 R4 R5 reset state
        chk(core_rst, 1, "R1 hold at power-on");
        chk(osc_en, 1, "R1 osc during hold");
        chk(reg_load, 1, "R2 reg_load");
        chk(pc_rst_val, {PCW{1'b1}}, "R2 pc value");
        chk(tcr_rst_val, 8'hBF, "R2 tcr value");
        chk(iocr_and_mask, 8'hB7, "R2 iocr and");
        chk(iocr_or_mask, 8'h31, "R2 iocr or");
        chk(por_load, 1, "R3 por_load at power-on");
        chk({wdt_clr, wdt_run}, 2'b10, "R4 wdt in hold");
        chk({flag_t, flag_p}, 2'b11, "R5 power-on flags");
        por_det = 1'b0;
        hold_len(n);
        chk(n, OST, "R1 power-on hold length");
        chk({por_load, wdt_run, wdt_clr}, 3'b010, "R4 run after hold");

        // R5 watchdog while running
        pulse_wdt();
        chk({core_rst, por_load}, 2'b10, "R3 wdt hold no por_load");
        chk({flag_t, flag_p}, 2'b01, "R5 wdt running flags");
        hold_len(n);
        chk(n, OST, "R1 wdt hold length");

        // R10 R11 external reset while running
        ext_rst_n = 1'b0; cyc(2);
        chk(core_rst, 0, "R11 sync latency not yet");
        cyc(1);
        chk(core_rst, 1, "R11 reset on third edge");
        cyc(OST + 5);
        chk(core_rst, 1, "R10 hold while pin low");
        chk({flag_t, flag_p}, 2'b01, "R10 flags unchanged");
        ext_rst_n = 1'b1;
        hold_len(n);
        chk(n, OST + 2, "R10 hold after pin release");

        // R4 watchdog disabled
        cfg_wdt_en = 1'b0; cyc(1);
        chk(wdt_run, 0, "R4 wdt_run follows option");
        pulse_wdt(); cyc(1);
        chk(core_rst, 0, "R4 disabled timeout ignored");
        cfg_wdt_en = 1'b1;

        // R6 R7 light-off sleep
        do_sleep(1'b1);
        chk({osc_en, wdt_clr, wdt_run}, 3'b011, "R6 sleep1 entry");
        cyc(1);
        chk(wdt_clr, 0, "R6 clear pulse one cycle");
        wake_en = '1; pin_in_mode = '1; wake_n = '0; cyc(5);
        chk({osc_en, core_rst}, 2'b00, "R6 wake pins ignored");
        wake_n = '1; wake_en = '0; pin_in_mode = '0; cyc(3);
        pulse_wdt();
        chk({core_rst, flag_t, flag_p}, 3'b100, "R7 sleep1 wdt reset");
        hold_len(n);

        // R9 light-off sleep external reset
        do_sleep(1'b1);
        ext_rst_n = 1'b0; cyc(3);
        chk({core_rst, flag_t, flag_p}, 3'b110, "R9 sleep1 pin reset");
        ext_rst_n = 1'b1; hold_len(n);

        // R8 pin wake flags from a 01 start
        pulse_wdt(); hold_len(n);
        do_sleep(1'b0);
        chk(osc_en, 0, "R8 sleep2 osc off");
        wake_en = 3'b010; pin_in_mode = 3'b010; wake_n = 3'b101; cyc(4);
        chk({core_rst, osc_en, flag_t, flag_p}, 4'b0110, "R8 pin wake flags");
        wake_n = '1; wake_en = '0; pin_in_mode = '0; cyc(3);

        // R8 sweep of qualifier
        for (int e = 0; e < 8; e++) begin
            for (int m = 0; m < 8; m++) begin
                for (int p = 0; p < 8; p++) begin
                    do_sleep(1'b0);
                    wake_en = 3'(e); pin_in_mode = 3'(m); wake_n = ~3'(p);
                    cyc(4);
                    exp = |(3'(e) & 3'(m) & 3'(p));
                    chk({core_rst, osc_en}, {1'b0, exp}, "R8 qualifier sweep");
                    if (!exp) begin
                        wake_en = '1; pin_in_mode = '1; wake_n = '0; cyc(4);
                    end
                    wake_n = '1; wake_en = '0; pin_in_mode = '0; cyc(3);
                end
            end
        end

        // R9 pin-wake sleep watchdog and pin reset
        do_sleep(1'b0);
        pulse_wdt();
        chk({core_rst, flag_t, flag_p}, 3'b100, "R9 sleep2 wdt reset");
        hold_len(n);
        chk(n, OST, "R9 sleep2 wdt hold length");
        do_sleep(1'b0);
        ext_rst_n = 1'b0; cyc(3);
        chk({core_rst, flag_t, flag_p}, 3'b110, "R9 sleep2 pin reset");
        ext_rst_n = 1'b1; hold_len(n);
        chk(core_rst, 0, "R9 returns to run");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule